// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a bank of interrupt sources and turns source activity into delivery requests for one presentation controller. Each source is either level-sensitive or edge/message-signalled, chosen by a static type pin. For each source the block holds a destination server, a priority and a set of status flags (asserted, sent, rejected, masked-pending, queued). The all-ones priority value means that the source is masked.

Requests leave on a valid/ready port. Each carries a global source number, equal to a base offset plus the local index, along with the source's priority and server. The presentation side answers with reject and end-of-interrupt messages, which carry global numbers, and with a resend command. The resend command walks every source in index order and re-offers whatever the rules allow. Several sources can become ready in the same cycle. Each one sets its own queued flag, and an output slot drains these flags lowest index first, so no event is lost while the port is back-pressured. The back-pressure rules are these: while `req_valid` is high and `req_ready` is low, the request fields hold still, and a running resend scan stops advancing.

Top module: `isc_src_ctrl`

## Requirements
- R1: After reset every source is masked (priority all ones) with server 0 and every status flag clear. `req_valid` and `resend_busy` are low. The source types come from `src_lsi` (bit set = level-sensitive) and are not affected by reset.
- R2: A high `src_in` bit on a message source whose priority is all ones sets masked-pending and sends nothing.
- R3: A high `src_in` bit on an unmasked message source queues one request with number BASE+index, the stored priority and the stored server.
- R4: A configuration write sets the server and priority of source `cfg_idx`. On a message source with masked-pending set, a new priority other than all ones queues a request and clears masked-pending. A masked priority leaves masked-pending set. On a level source, the write runs the level check.
- R5: A level source copies `src_in` into its asserted flag whenever the input differs from the flag, and then runs the level check. The check queues a request and sets the sent flag only if the source is unmasked, asserted and not yet sent.
- R6: A reject sets the rejected flag of a message source and clears the sent flag of a level source. Reject and EOI numbers outside BASE to BASE+NSRC-1 change nothing.
- R7: An EOI clears the sent flag of a level source and has no effect on a message source.
- R8: `resend_start` while idle starts a scan that visits indices 0 to NSRC-1, one per cycle. A visited message source with the rejected flag set clears that flag and requeues only if unmasked. A visited level source runs the level check. `resend_start` is ignored while a scan is running.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_num`, `req_prio` and `req_server` hold still. Queued sources are loaded into the port lowest index first, with the priority and server that hold at load time.
- R10: A resend scan does not advance while the request port holds an unaccepted request.
- R11: Within one cycle a source applies reject and EOI first, then a configuration write, then its input, then the scan visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lsi | input | NSRC | Per-source type: 1 level-sensitive, 0 message |
| src_in | input | NSRC | Level for level sources, one-cycle trigger for message sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Local index of the source to configure |
| cfg_server | input | SRVW | New destination server |
| cfg_prio | input | PRIW | New priority (all ones masks the source) |
| rej_valid | input | 1 | Reject message strobe |
| rej_num | input | NUMW | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUMW | Global number being completed |
| resend_start | input | 1 | Start a resend scan |
| resend_busy | output | 1 | Scan in progress |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Presentation side accepts the request |
| req_num | output | NUMW | Global source number |
| req_prio | output | PRIW | Request priority |
| req_server | output | SRVW | Destination server |

## Verification
Most internal state in this block is visible only through later traffic. A wrong sent or rejected flag is hidden until the next input change, EOI or resend scan. A lost masked-pending flag is hidden until the next unmasking write. The bench therefore keeps driving rejects, EOIs, resend scans and priority changes against a behavioural model of every source, and compares the port every cycle. A fault in the queue or the output slot shows within a cycle or two as a wrong number, priority or server, or as a wrong valid. A fault in the flags shows at the first later event that reads them.

// File: rtl/isc_pkg.sv
package isc_pkg;
  // per-source status flags
  typedef struct packed {
    logic asr;    // level input currently high (level sources)
    logic sent;   // request delivered, awaiting EOI/reject (level sources)
    logic rej;    // request was refused (message sources)
    logic mpend;  // trigger seen while masked (message sources)
    logic queued; // waiting for the request port
  } isc_stat_t;
endpackage

// File: rtl/isc_slot.sv
module isc_slot
  import isc_pkg::*;
#(
  parameter int PRIW = 8,
  parameter int SRVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_lsi,
  input  logic            lvl,
  input  logic            cfg_hit,
  input  logic [SRVW-1:0] cfg_srv,
  input  logic [PRIW-1:0] cfg_pri,
  input  logic            rej_hit,
  input  logic            eoi_hit,
  input  logic            scan_hit,
  input  logic            grant,
  output logic            want,
  output logic [PRIW-1:0] prio,
  output logic [SRVW-1:0] srv
);
  localparam logic [PRIW-1:0] MASKED = {PRIW{1'b1}};

  isc_stat_t       st_q, st_d;
  logic [PRIW-1:0] pri_q, pri_d;
  logic [SRVW-1:0] srv_q, srv_d;

  always_comb begin
    logic chk;
    logic send;
    st_d  = st_q;
    pri_d = pri_q;
    srv_d = srv_q;
    chk   = 1'b0;
    send  = 1'b0;
    // R11: messages from the presentation side first
    if (rej_hit) begin
      if (is_lsi) st_d.sent = 1'b0;
      else        st_d.rej  = 1'b1;
    end
    if (eoi_hit && is_lsi) st_d.sent = 1'b0;
    // configuration write
    if (cfg_hit) begin
      pri_d = cfg_pri;
      srv_d = cfg_srv;
      if (is_lsi) chk = 1'b1;
      else if (st_d.mpend && cfg_pri != MASKED) begin
        st_d.mpend = 1'b0;
        send       = 1'b1;
      end
    end
    // source input
    if (is_lsi) begin
      if (lvl != st_d.asr) begin
        st_d.asr = lvl;
        chk      = 1'b1;
      end
    end else if (lvl) begin
      if (pri_d == MASKED) st_d.mpend = 1'b1;
      else                 send       = 1'b1;
    end
    // resend scan visit
    if (scan_hit) begin
      if (is_lsi) chk = 1'b1;
      else if (st_d.rej) begin
        st_d.rej = 1'b0;
        if (pri_d != MASKED) send = 1'b1;
      end
    end
    // level check
    if (chk && pri_d != MASKED && st_d.asr && !st_d.sent) begin
      st_d.sent = 1'b1;
      send      = 1'b1;
    end
    st_d.queued = (st_q.queued && !grant) || send;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      pri_q <= MASKED;
      srv_q <= '0;
    end else begin
      st_q  <= st_d;
      pri_q <= pri_d;
      srv_q <= srv_d;
    end
  end

  assign want = st_q.queued;
  assign prio = pri_q;
  assign srv  = srv_q;
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    want,
  output logic            any,
  output logic [IDXW-1:0] idx,
  output logic [N-1:0]    onehot
);
  always_comb begin
    any    = |want;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) begin
        idx    = IDXW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         hold,
  output logic         busy,
  output logic [N-1:0] hit
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  logic [IDXW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (busy) begin
      if (!hold) begin
        if (ptr == LAST) busy <= 1'b0;
        else             ptr  <= ptr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = busy && !hold && (ptr == IDXW'(i));
  end
endmodule

// File: rtl/isc_src_ctrl.sv
module isc_src_ctrl #(
  parameter int          NSRC = 8,
  parameter int          PRIW = 8,
  parameter int          SRVW = 4,
  parameter int          NUMW = 16,
  parameter int unsigned BASE = 32'h1000,
  localparam int         IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lsi,
  input  logic [NSRC-1:0] src_in,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [SRVW-1:0] cfg_server,
  input  logic [PRIW-1:0] cfg_prio,
  input  logic            rej_valid,
  input  logic [NUMW-1:0] rej_num,
  input  logic            eoi_valid,
  input  logic [NUMW-1:0] eoi_num,
  input  logic            resend_start,
  output logic            resend_busy,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [NUMW-1:0] req_num,
  output logic [PRIW-1:0] req_prio,
  output logic [SRVW-1:0] req_server
);
  logic [NSRC-1:0] want, grant, onehot, scan_hit;
  logic [PRIW-1:0] pri_a [NSRC];
  logic [SRVW-1:0] srv_a [NSRC];
  logic            any, load, port_hold;
  logic [IDXW-1:0] pick;

  assign port_hold = req_valid && !req_ready;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [NUMW-1:0] GNUM = NUMW'(BASE + i);
    isc_slot #(.PRIW(PRIW), .SRVW(SRVW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_lsi   (src_lsi[i]),
      .lvl      (src_in[i]),
      .cfg_hit  (cfg_we && cfg_idx == IDXW'(i)),
      .cfg_srv  (cfg_server),
      .cfg_pri  (cfg_prio),
      .rej_hit  (rej_valid && rej_num == GNUM),
      .eoi_hit  (eoi_valid && eoi_num == GNUM),
      .scan_hit (scan_hit[i]),
      .grant    (grant[i]),
      .want     (want[i]),
      .prio     (pri_a[i]),
      .srv      (srv_a[i])
    );
  end

  isc_pick #(.N(NSRC), .IDXW(IDXW)) u_pick (
    .want   (want),
    .any    (any),
    .idx    (pick),
    .onehot (onehot)
  );

  isc_scan #(.N(NSRC), .IDXW(IDXW)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (resend_start),
    .hold  (port_hold),
    .busy  (resend_busy),
    .hit   (scan_hit)
  );

  assign load  = any && !port_hold;
  assign grant = load ? onehot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_num    <= '0;
      req_prio   <= '0;
      req_server <= '0;
    end else if (load) begin
      req_valid  <= 1'b1;
      req_num    <= NUMW'(BASE) + NUMW'(pick);
      req_prio   <= pri_a[pick];
      req_server <= srv_a[pick];
    end else if (req_ready) begin
      req_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/isc_src_ctrl_chk.sv
module isc_src_ctrl_chk #(
  parameter int          NSRC = 8,
  parameter int          PRIW = 8,
  parameter int          SRVW = 4,
  parameter int          NUMW = 16,
  parameter int unsigned BASE = 32'h1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            resend_start,
  input logic            resend_busy,
  input logic            req_valid,
  input logic            req_ready,
  input logic [NUMW-1:0] req_num,
  input logic [PRIW-1:0] req_prio,
  input logic [SRVW-1:0] req_server
);
  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_num)
      && $stable(req_prio) && $stable(req_server));

  a_r3_num_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_num >= NUMW'(BASE)) && (req_num < NUMW'(BASE + NSRC)));

  a_r8_scan_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resend_busy) |-> $past(resend_start));

  a_r10_scan_stall: assert property (@(posedge clk) disable iff (!rst_n)
    resend_busy && req_valid && !req_ready |=> resend_busy);
endmodule

bind isc_src_ctrl isc_src_ctrl_chk #(
  .NSRC(NSRC), .PRIW(PRIW), .SRVW(SRVW), .NUMW(NUMW), .BASE(BASE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .resend_start (resend_start),
  .resend_busy  (resend_busy),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_num      (req_num),
  .req_prio     (req_prio),
  .req_server   (req_server)
);

// File: tb/test_isc_src_ctrl.sv
`timescale 1ns/1ps
module test_isc_src_ctrl;
  localparam int N = 8;
  localparam int B = 32'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_lsi = 8'hF0;  // 0..3 message, 4..7 level
  logic [N-1:0] src_in = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [3:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic rej_valid = 1'b0, eoi_valid = 1'b0, resend_start = 1'b0;
  logic [15:0] rej_num = '0, eoi_num = '0;
  logic req_ready = 1'b1;
  logic resend_busy, req_valid;
  logic [15:0] req_num;
  logic [7:0] req_prio;
  logic [3:0] req_server;

  always #4 clk = ~clk;  // 125 MHz

  isc_src_ctrl i_isc_src_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lsi(src_lsi), .src_in(src_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_start(resend_start),
    .resend_busy(resend_busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_prio(req_prio), .req_server(req_server)
  );

  // behavioural model
  int m_pri [N];
  int m_srv [N];
  bit m_asr [N], m_sent [N], m_rej [N], m_mp [N], m_q [N];
  bit m_ov, m_busy;
  int m_num, m_prio, m_server, m_ptr;

  int compared = 0, mismatched = 0, cyc = 0;
  string phase = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pri[i] = 255; m_srv[i] = 0;
        m_asr[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_q[i] = 0;
      end
      m_ov = 0; m_busy = 0; m_ptr = 0;
    end else begin
      bit stall;
      int g;
      int vis;
      stall = m_ov && !req_ready;
      g = -1;
      for (int i = N - 1; i >= 0; i--) if (m_q[i]) g = i;
      if (g >= 0 && !stall) begin
        m_ov = 1; m_num = B + g; m_prio = m_pri[g]; m_server = m_srv[g];
        m_q[g] = 0;
      end else if (req_ready) m_ov = 0;
      vis = (m_busy && !stall) ? m_ptr : -1;
      for (int i = 0; i < N; i++) begin
        bit chk, snd;
        chk = 0; snd = 0;
        if (rej_valid && rej_num == 16'(B + i)) begin
          if (src_lsi[i]) m_sent[i] = 0; else m_rej[i] = 1;
        end
        if (eoi_valid && eoi_num == 16'(B + i) && src_lsi[i]) m_sent[i] = 0;
        if (cfg_we && cfg_idx == 3'(i)) begin
          m_pri[i] = cfg_prio; m_srv[i] = cfg_server;
          if (src_lsi[i]) chk = 1;
          else if (m_mp[i] && cfg_prio != 8'hFF) begin m_mp[i] = 0; snd = 1; end
        end
        if (src_lsi[i]) begin
          if (src_in[i] != m_asr[i]) begin m_asr[i] = src_in[i]; chk = 1; end
        end else if (src_in[i]) begin
          if (m_pri[i] == 255) m_mp[i] = 1; else snd = 1;
        end
        if (vis == i) begin
          if (src_lsi[i]) chk = 1;
          else if (m_rej[i]) begin m_rej[i] = 0; if (m_pri[i] != 255) snd = 1; end
        end
        if (chk && m_pri[i] != 255 && m_asr[i] && !m_sent[i]) begin
          m_sent[i] = 1; snd = 1;
        end
        if (snd) m_q[i] = 1;
      end
      if (m_busy) begin
        if (!stall) begin
          if (m_ptr == N - 1) m_busy = 0; else m_ptr++;
        end
      end else if (resend_start) begin
        m_busy = 1; m_ptr = 0;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    compared++;
    if (req_valid !== m_ov || resend_busy !== m_busy ||
        (m_ov && (req_num !== 16'(m_num) || req_prio !== 8'(m_prio) ||
                  req_server !== 4'(m_server)))) begin
      mismatched++;
      $display("FAIL %s t=%0t valid/busy/num/prio/srv = %0d/%0d/%h/%h/%h exp %0d/%0d/%h/%h/%h",
               phase, $time, req_valid, resend_busy, req_num, req_prio, req_server,
               m_ov, m_busy, m_num, m_prio, m_server);
    end
  end

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic idle;
    src_in = src_in & src_lsi;  // message triggers are single-cycle
    cfg_we = 0; rej_valid = 0; eoi_valid = 0; resend_start = 0;
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1; idle();
    end
  endtask

  task automatic cfg(int idx, int srv, int pri);
    @(negedge clk); #1; idle();
    cfg_we = 1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(pri);
  endtask

  task automatic trig(int idx);
    @(negedge clk); #1; idle(); src_in[idx] = 1;
  endtask

  task automatic rej(int num);
    @(negedge clk); #1; idle(); rej_valid = 1; rej_num = 16'(num);
  endtask

  task automatic eoi(int num);
    @(negedge clk); #1; idle(); eoi_valid = 1; eoi_num = 16'(num);
  endtask

  task automatic resend;
    @(negedge clk); #1; idle(); resend_start = 1;
  endtask

  initial begin
    tick(3);
    @(negedge clk); #1; rst_n = 1;
    tick(2);
    phase = "R2"; trig(1); tick(3);
    phase = "R4"; cfg(1, 3, 8'hFF); tick(2); cfg(1, 3, 5); tick(3);
    phase = "R3"; cfg(0, 2, 9); trig(0); tick(3);
    phase = "R5"; cfg(4, 7, 3); tick(1);
    @(negedge clk); #1; idle(); src_in[4] = 1; tick(4);
    phase = "R7"; eoi(B + 4); tick(2); eoi(B + 0); tick(2);
    phase = "R8"; resend; tick(12); resend; resend; tick(12);
    phase = "R6"; rej(B + 0); tick(1); rej(B + 20); tick(1); rej(B - 1); tick(1);
    resend; tick(12);
    cfg(0, 2, 8'hFF); rej(B + 0); resend; tick(12);
    phase = "R9";
    @(negedge clk); #1; idle(); req_ready = 0;
    cfg(2, 1, 4); cfg(3, 6, 2); trig(3); trig(2); tick(4);
    phase = "R10"; resend; tick(5);
    @(negedge clk); #1; idle(); req_ready = 1; tick(14);
    phase = "R11";
    @(negedge clk); #1; idle(); rej_valid = 1; rej_num = 16'(B + 4);
    cfg_we = 1; cfg_idx = 3'd4; cfg_server = 4'd1; cfg_prio = 8'd6; tick(4);
    @(negedge clk); #1; idle(); src_in[4] = 0; tick(2);
    phase = "R1";
    @(negedge clk); #1; idle(); rst_n = 0; tick(3);
    @(negedge clk); #1; rst_n = 1; src_in = '0; tick(3);
    phase = "RND";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1; idle();
      req_ready = ($urandom_range(0, 3) != 0);
      for (int i = 0; i < N; i++) begin
        if (src_lsi[i]) begin
          if ($urandom_range(0, 15) == 0) src_in[i] = ~src_in[i];
        end else src_in[i] = ($urandom_range(0, 9) == 0);
      end
      if ($urandom_range(0, 5) == 0) begin
        cfg_we = 1; cfg_idx = 3'($urandom_range(0, N - 1));
        cfg_server = 4'($urandom); cfg_prio = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      end
      if ($urandom_range(0, 4) == 0) begin
        rej_valid = 1; rej_num = 16'(B - 2 + $urandom_range(0, 11));
      end
      if ($urandom_range(0, 4) == 0) begin
        eoi_valid = 1; eoi_num = 16'(B - 2 + $urandom_range(0, 11));
      end
      resend_start = ($urandom_range(0, 19) == 0);
    end
    tick(20);
    report();
  end
endmodule